// File: doc/BRIEF.md
# Process-Tagged Translation Cache with Execute Permission

This block is a small, fully associative cache of virtual-to-physical page translations. Every stored translation carries an address-space identifier next to its virtual page number, so translations that belong to different tasks or virtual machines can sit side by side. A context switch therefore needs no flush. A lookup compares the presented page number and identifier against every entry at once. One cycle later it reports a hit with the physical page and two attribute bits: strongly-ordered access, and writeback versus write-through caching. Otherwise it reports a miss, which the surrounding logic uses to start a page-table walk.

Each entry also holds an execute-never flag. An instruction fetch that lands on such a page produces a permission fault rather than a translation. A data access to the same page still translates normally.

New translations arrive on a refill port, usually from the table walker. Stale ones are removed through an invalidation port, which coherency messages from elsewhere in the system drive. Invalidation can remove one page of one identifier, every page of one identifier, or everything. Each form takes effect in a single cycle.

Top module: `asid_tlb`

## Requirements
- R1: While reset is asserted, and after it is released, every entry is invalid and the result outputs (hit, miss, fault, page, attributes) are zero. A lookup after reset misses, even when a refill was made before the reset.
- R2: A lookup request produces exactly one of hit, miss or fault on the clock edge that follows it, for one cycle. A cycle with no lookup request leaves all three low on the following edge.
- R3: A hit needs a valid entry whose page number and identifier both equal the request. All entries are compared in parallel. The hit returns that entry's physical page, its strongly-ordered bit and its writeback bit.
- R4: Two entries with the same virtual page and different identifiers coexist. Each returns its own translation, and a lookup under an identifier that has no entry misses.
- R5: A lookup marked as an instruction fetch that hits an execute-never entry raises fault rather than hit. The same page hits for a data access, and a fetch to a page without execute-never hits.
- R6: The physical page and attribute outputs are zero in every cycle in which hit is low.
- R7: A refill whose page and identifier are not already present goes to the lowest-numbered invalid entry.
- R8: When every entry is valid, a new refill replaces the entry named by a round-robin pointer. After reset the pointer names entry 0. It moves on by one after each such replacement and wraps from the last entry to entry 0.
- R9: A refill whose page and identifier match a valid entry overwrites that entry in place. It takes no free entry and does not move the round-robin pointer, so a lookup never matches two entries.
- R10: Invalidation mode 2'b00 removes only the entry that matches both the given page and identifier.
- R11: Invalidation mode 2'b01 removes every entry of the given identifier and leaves the others.
- R12: Invalidation modes 2'b10 and 2'b11 remove every entry.
- R13: A lookup sees the contents from before the edge that ends its cycle. When a refill and an invalidation come in the same cycle, the invalidation acts first and the refilled entry is valid afterwards. Its slot is chosen from the contents before the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| lkValid | input | 1 | Lookup request |
| lkVpn | input | VPN_W | Virtual page number to translate |
| lkAsid | input | ASID_W | Address-space identifier of the request |
| lkIsFetch | input | 1 | Request is an instruction fetch |
| rsHit | output | 1 | Translation found and allowed |
| rsMiss | output | 1 | No matching entry; start a walk |
| rsFault | output | 1 | Fetch hit an execute-never page |
| rsPpn | output | PPN_W | Physical page number on hit, else zero |
| rsStrongOrd | output | 1 | Strongly-ordered attribute on hit |
| rsWriteBack | output | 1 | Writeback (1) or write-through (0) on hit |
| rfValid | input | 1 | Refill request |
| rfVpn | input | VPN_W | Refill virtual page number |
| rfAsid | input | ASID_W | Refill identifier |
| rfPpn | input | PPN_W | Refill physical page number |
| rfExecNever | input | 1 | Refill execute-never flag |
| rfStrongOrd | input | 1 | Refill strongly-ordered flag |
| rfWriteBack | input | 1 | Refill writeback flag |
| ivValid | input | 1 | Invalidation request |
| ivMode | input | 2 | 00 one page of one identifier, 01 one identifier, 1x everything |
| ivVpn | input | VPN_W | Page for mode 00 |
| ivAsid | input | ASID_W | Identifier for modes 00 and 01 |

## Verification
The bench builds the block with four entries, 8-bit virtual and physical page numbers and 4-bit identifiers. With only four entries, filling the store, using up free slots and running the round-robin pointer through a full wrap takes just a few refills. A small identifier and page space makes it easy to set up same-page, different-identifier pairs. The 8-bit physical pages are chosen so that a double match would OR two distinct values together, so a duplicate entry shows up as a wrong page number.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Invalidation mode encodings on ivMode
  localparam logic [1:0] INV_ONE  = 2'b00;
  localparam logic [1:0] INV_ASID = 2'b01;

  // Strobes from control to datapath for one clock cycle
  typedef struct packed {
    logic write;    // write refill data into entry wrIdx
    logic clrOne;   // clear entry matching page and identifier
    logic clrAsid;  // clear entries of one identifier
    logic clrAll;   // clear every entry
  } tlbStrobeT;

endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rfValid,
  input  logic               ivValid,
  input  logic [1:0]         ivMode,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] rfMatchVec,
  output tlbStrobeT          strobe,
  output logic [IDX_W-1:0]   wrIdx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] freeIdx;
  logic [IDX_W-1:0] matchIdx;
  logic [IDX_W-1:0] rrPtr;
  logic             hasFree;
  logic             hasMatch;
  logic             useVictim;

  // Lowest-numbered invalid entry and lowest-numbered matching entry
  always_comb begin
    freeIdx  = '0;
    hasFree  = 1'b0;
    matchIdx = '0;
    hasMatch = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i]) begin
        freeIdx = IDX_W'(i);
        hasFree = 1'b1;
      end
      if (rfMatchVec[i]) begin
        matchIdx = IDX_W'(i);
        hasMatch = 1'b1;
      end
    end
  end

  assign useVictim = rfValid && !hasMatch && !hasFree;

  always_comb begin
    if (hasMatch)     wrIdx = matchIdx;
    else if (hasFree) wrIdx = freeIdx;
    else              wrIdx = rrPtr;
  end

  // Round-robin victim pointer, moves only when it was used
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (useVictim) begin
      rrPtr <= (rrPtr == LAST_IDX) ? '0 : rrPtr + 1'b1;
    end
  end

  always_comb begin
    strobe.write   = rfValid;
    strobe.clrOne  = ivValid && (ivMode == INV_ONE);
    strobe.clrAsid = ivValid && (ivMode == INV_ASID);
    strobe.clrAll  = ivValid && ivMode[1];
  end

endmodule

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int ASID_W  = 8,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  tlbStrobeT          strobe,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [VPN_W-1:0]   rfVpn,
  input  logic [ASID_W-1:0]  rfAsid,
  input  logic [PPN_W-1:0]   rfPpn,
  input  logic               rfExecNever,
  input  logic               rfStrongOrd,
  input  logic               rfWriteBack,
  input  logic [VPN_W-1:0]   ivVpn,
  input  logic [ASID_W-1:0]  ivAsid,
  input  logic               lkValid,
  input  logic [VPN_W-1:0]   lkVpn,
  input  logic [ASID_W-1:0]  lkAsid,
  input  logic               lkIsFetch,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] rfMatchVec,
  output logic [ENTRIES-1:0] hitVec,
  output logic               rsHit,
  output logic               rsMiss,
  output logic               rsFault,
  output logic [PPN_W-1:0]   rsPpn,
  output logic               rsStrongOrd,
  output logic               rsWriteBack
);

  logic [PPN_W-1:0]   ppnMasked [ENTRIES];
  logic [ENTRIES-1:0] xnHitVec;
  logic [ENTRIES-1:0] soHitVec;
  logic [ENTRIES-1:0] wbHitVec;

  for (genvar g = 0; g < ENTRIES; g++) begin : gEntry
    logic              validQ;
    logic [VPN_W-1:0]  vpnQ;
    logic [ASID_W-1:0] asidQ;
    logic [PPN_W-1:0]  ppnQ;
    logic              xnQ;
    logic              soQ;
    logic              wbQ;
    logic              clrHit;
    logic              wrHere;

    assign wrHere = strobe.write && (wrIdx == IDX_W'(g));
    assign clrHit = strobe.clrAll
                  | (strobe.clrAsid && (asidQ == ivAsid))
                  | (strobe.clrOne && (asidQ == ivAsid) && (vpnQ == ivVpn));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validQ <= 1'b0;
        vpnQ   <= '0;
        asidQ  <= '0;
        ppnQ   <= '0;
        xnQ    <= 1'b0;
        soQ    <= 1'b0;
        wbQ    <= 1'b0;
      end else if (wrHere) begin
        validQ <= 1'b1;
        vpnQ   <= rfVpn;
        asidQ  <= rfAsid;
        ppnQ   <= rfPpn;
        xnQ    <= rfExecNever;
        soQ    <= rfStrongOrd;
        wbQ    <= rfWriteBack;
      end else if (clrHit) begin
        validQ <= 1'b0;
      end
    end

    assign validVec[g]   = validQ;
    assign hitVec[g]     = validQ && (vpnQ == lkVpn) && (asidQ == lkAsid);
    assign rfMatchVec[g] = validQ && (vpnQ == rfVpn) && (asidQ == rfAsid);
    assign ppnMasked[g]  = hitVec[g] ? ppnQ : '0;
    assign xnHitVec[g]   = hitVec[g] & xnQ;
    assign soHitVec[g]   = hitVec[g] & soQ;
    assign wbHitVec[g]   = hitVec[g] & wbQ;
  end

  logic [PPN_W-1:0] selPpn;
  logic             anyHit;
  logic             blockFetch;
  logic             okHit;

  always_comb begin
    selPpn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      selPpn = selPpn | ppnMasked[i];
    end
  end

  assign anyHit     = |hitVec;
  assign blockFetch = lkIsFetch && (|xnHitVec);
  assign okHit      = lkValid && anyHit && !blockFetch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rsHit       <= 1'b0;
      rsMiss      <= 1'b0;
      rsFault     <= 1'b0;
      rsPpn       <= '0;
      rsStrongOrd <= 1'b0;
      rsWriteBack <= 1'b0;
    end else begin
      rsHit       <= okHit;
      rsMiss      <= lkValid && !anyHit;
      rsFault     <= lkValid && anyHit && blockFetch;
      rsPpn       <= okHit ? selPpn : '0;
      rsStrongOrd <= okHit && (|soHitVec);
      rsWriteBack <= okHit && (|wbHitVec);
    end
  end

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int ASID_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkValid,
  input  logic [VPN_W-1:0]  lkVpn,
  input  logic [ASID_W-1:0] lkAsid,
  input  logic              lkIsFetch,
  output logic              rsHit,
  output logic              rsMiss,
  output logic              rsFault,
  output logic [PPN_W-1:0]  rsPpn,
  output logic              rsStrongOrd,
  output logic              rsWriteBack,
  input  logic              rfValid,
  input  logic [VPN_W-1:0]  rfVpn,
  input  logic [ASID_W-1:0] rfAsid,
  input  logic [PPN_W-1:0]  rfPpn,
  input  logic              rfExecNever,
  input  logic              rfStrongOrd,
  input  logic              rfWriteBack,
  input  logic              ivValid,
  input  logic [1:0]        ivMode,
  input  logic [VPN_W-1:0]  ivVpn,
  input  logic [ASID_W-1:0] ivAsid
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  tlbStrobeT          strobe;
  logic [IDX_W-1:0]   wrIdx;
  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] rfMatchVec;
  logic [ENTRIES-1:0] hitVec;

  tlb_ctrl #(.ENTRIES(ENTRIES)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .rfValid    (rfValid),
    .ivValid    (ivValid),
    .ivMode     (ivMode),
    .validVec   (validVec),
    .rfMatchVec (rfMatchVec),
    .strobe     (strobe),
    .wrIdx      (wrIdx)
  );

  tlb_datapath #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .PPN_W   (PPN_W),
    .ASID_W  (ASID_W)
  ) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wrIdx       (wrIdx),
    .rfVpn       (rfVpn),
    .rfAsid      (rfAsid),
    .rfPpn       (rfPpn),
    .rfExecNever (rfExecNever),
    .rfStrongOrd (rfStrongOrd),
    .rfWriteBack (rfWriteBack),
    .ivVpn       (ivVpn),
    .ivAsid      (ivAsid),
    .lkValid     (lkValid),
    .lkVpn       (lkVpn),
    .lkAsid      (lkAsid),
    .lkIsFetch   (lkIsFetch),
    .validVec    (validVec),
    .rfMatchVec  (rfMatchVec),
    .hitVec      (hitVec),
    .rsHit       (rsHit),
    .rsMiss      (rsMiss),
    .rsFault     (rsFault),
    .rsPpn       (rsPpn),
    .rsStrongOrd (rsStrongOrd),
    .rsWriteBack (rsWriteBack)
  );

endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
  parameter int ENTRIES = 16,
  parameter int PPN_W   = 20
) (
  input logic               clk,
  input logic               rstN,
  input logic               lkValid,
  input logic               lkIsFetch,
  input logic               rsHit,
  input logic               rsMiss,
  input logic               rsFault,
  input logic [PPN_W-1:0]   rsPpn,
  input logic               rsStrongOrd,
  input logic               rsWriteBack,
  input logic               rfValid,
  input logic               flushAll,
  input logic [ENTRIES-1:0] validVec,
  input logic [ENTRIES-1:0] hitVec
);

  assert_one_result_R2: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> ($countones({rsHit, rsMiss, rsFault}) == 1));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !(rsHit || rsMiss || rsFault));

  assert_fault_on_fetch_R5: assert property (@(posedge clk) disable iff (!rstN)
    rsFault |-> $past(lkIsFetch));

  assert_zero_without_hit_R6: assert property (@(posedge clk) disable iff (!rstN)
    !rsHit |-> (rsPpn == '0 && !rsStrongOrd && !rsWriteBack));

  assert_refill_lands_R7: assert property (@(posedge clk) disable iff (!rstN)
    rfValid |=> (validVec != '0));

  assert_single_match_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  assert_flush_empties_R12: assert property (@(posedge clk) disable iff (!rstN)
    (flushAll && !rfValid) |=> (validVec == '0));

endmodule

bind asid_tlb tlb_checker #(.ENTRIES(ENTRIES), .PPN_W(PPN_W)) i_tlbChecker (
  .clk         (clk),
  .rstN        (rstN),
  .lkValid     (lkValid),
  .lkIsFetch   (lkIsFetch),
  .rsHit       (rsHit),
  .rsMiss      (rsMiss),
  .rsFault     (rsFault),
  .rsPpn       (rsPpn),
  .rsStrongOrd (rsStrongOrd),
  .rsWriteBack (rsWriteBack),
  .rfValid     (rfValid),
  .flushAll    (ivValid && ivMode[1]),
  .validVec    (validVec),
  .hitVec      (hitVec)
);

// File: tb/test_asid_tlb.sv
`timescale 1ns/1ps
module test_asid_tlb;

  localparam int ENTRIES = 4;
  localparam int VPN_W   = 8;
  localparam int PPN_W   = 8;
  localparam int ASID_W  = 4;

  // kind: 0 refill, 1 lookup, 2 invalidate
  // flg: refill {xn,so,wb}; lookup flg[0]=fetch; invalidate flg[1:0]=mode
  // res: 0 no result, 1 hit, 2 miss, 3 fault; eAttr = {so,wb}
  typedef struct packed {
    logic [1:0] kind;
    logic [7:0] vpn;
    logic [3:0] asid;
    logic [7:0] ppn;
    logic [2:0] flg;
    logic [1:0] res;
    logic [7:0] ePpn;
    logic [1:0] eAttr;
    logic [3:0] req;
  } vecT;

  function automatic vecT mkRefill(logic [7:0] vpn, logic [3:0] asid,
                                   logic [7:0] ppn, logic [2:0] flg, logic [3:0] req);
    return '{kind: 2'd0, vpn: vpn, asid: asid, ppn: ppn, flg: flg,
             res: 2'd0, ePpn: 8'h00, eAttr: 2'b00, req: req};
  endfunction

  function automatic vecT mkLook(logic [7:0] vpn, logic [3:0] asid, logic fetch,
                                 logic [1:0] res, logic [7:0] ePpn, logic [1:0] eAttr,
                                 logic [3:0] req);
    return '{kind: 2'd1, vpn: vpn, asid: asid, ppn: 8'h00, flg: {2'b00, fetch},
             res: res, ePpn: ePpn, eAttr: eAttr, req: req};
  endfunction

  function automatic vecT mkInv(logic [7:0] vpn, logic [3:0] asid,
                                logic [1:0] mode, logic [3:0] req);
    return '{kind: 2'd2, vpn: vpn, asid: asid, ppn: 8'h00, flg: {1'b0, mode},
             res: 2'd0, ePpn: 8'h00, eAttr: 2'b00, req: req};
  endfunction

  localparam int NVEC = 35;
  localparam vecT VEC [NVEC] = '{
    mkLook  (8'h10, 4'd1, 1'b0, 2'd2, 8'h00, 2'b00, 4'd1),  // R1 empty after reset
    mkRefill(8'h10, 4'd1, 8'hA1, 3'b001, 4'd7),             // R7 slot 0
    mkLook  (8'h10, 4'd1, 1'b0, 2'd1, 8'hA1, 2'b01, 4'd3),  // R3
    mkLook  (8'h10, 4'd2, 1'b0, 2'd2, 8'h00, 2'b00, 4'd4),  // R4 other id
    mkRefill(8'h10, 4'd2, 8'hB2, 3'b010, 4'd4),             // R4 slot 1
    mkLook  (8'h10, 4'd2, 1'b0, 2'd1, 8'hB2, 2'b10, 4'd4),  // R4
    mkLook  (8'h10, 4'd1, 1'b0, 2'd1, 8'hA1, 2'b01, 4'd4),  // R4
    mkRefill(8'h20, 4'd1, 8'hC3, 3'b101, 4'd5),             // R5 slot 2, xn
    mkLook  (8'h20, 4'd1, 1'b1, 2'd3, 8'h00, 2'b00, 4'd5),  // R5 fault
    mkLook  (8'h20, 4'd1, 1'b0, 2'd1, 8'hC3, 2'b01, 4'd5),  // R5 data ok
    mkLook  (8'h10, 4'd1, 1'b1, 2'd1, 8'hA1, 2'b01, 4'd5),  // R5 fetch ok
    mkRefill(8'h10, 4'd1, 8'hD4, 3'b000, 4'd9),             // R9 overwrite slot 0
    mkLook  (8'h10, 4'd1, 1'b0, 2'd1, 8'hD4, 2'b00, 4'd9),  // R9
    mkRefill(8'h30, 4'd3, 8'hE5, 3'b000, 4'd9),             // R9 slot 3, full
    mkRefill(8'h40, 4'd3, 8'hF6, 3'b000, 4'd8),             // R8 victim 0
    mkLook  (8'h10, 4'd1, 1'b0, 2'd2, 8'h00, 2'b00, 4'd8),  // R8
    mkLook  (8'h30, 4'd3, 1'b0, 2'd1, 8'hE5, 2'b00, 4'd8),  // R8
    mkRefill(8'h50, 4'd3, 8'h57, 3'b000, 4'd8),             // R8 victim 1
    mkLook  (8'h10, 4'd2, 1'b0, 2'd2, 8'h00, 2'b00, 4'd8),  // R8
    mkLook  (8'h20, 4'd1, 1'b0, 2'd1, 8'hC3, 2'b01, 4'd8),  // R8
    mkInv   (8'h50, 4'd3, 2'b00, 4'd10),                    // R10 slot 1
    mkLook  (8'h50, 4'd3, 1'b0, 2'd2, 8'h00, 2'b00, 4'd10), // R10
    mkLook  (8'h30, 4'd3, 1'b0, 2'd1, 8'hE5, 2'b00, 4'd10), // R10
    mkRefill(8'h60, 4'd1, 8'h61, 3'b000, 4'd7),             // R7 into slot 1
    mkLook  (8'h20, 4'd1, 1'b0, 2'd1, 8'hC3, 2'b01, 4'd7),  // R7
    mkLook  (8'h60, 4'd1, 1'b0, 2'd1, 8'h61, 2'b00, 4'd7),  // R7
    mkRefill(8'h70, 4'd2, 8'h72, 3'b000, 4'd8),             // R8 victim 2
    mkLook  (8'h20, 4'd1, 1'b0, 2'd2, 8'h00, 2'b00, 4'd8),  // R8
    mkInv   (8'h00, 4'd3, 2'b01, 4'd11),                    // R11 id 3
    mkLook  (8'h40, 4'd3, 1'b0, 2'd2, 8'h00, 2'b00, 4'd11), // R11
    mkLook  (8'h60, 4'd1, 1'b0, 2'd1, 8'h61, 2'b00, 4'd11), // R11
    mkLook  (8'h30, 4'd3, 1'b0, 2'd2, 8'h00, 2'b00, 4'd11), // R11
    mkInv   (8'h00, 4'd0, 2'b10, 4'd12),                    // R12
    mkLook  (8'h70, 4'd2, 1'b0, 2'd2, 8'h00, 2'b00, 4'd12), // R12
    mkLook  (8'h60, 4'd1, 1'b0, 2'd2, 8'h00, 2'b00, 4'd12)  // R12
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              lkValid = 1'b0;
  logic [VPN_W-1:0]  lkVpn = '0;
  logic [ASID_W-1:0] lkAsid = '0;
  logic              lkIsFetch = 1'b0;
  logic              rsHit;
  logic              rsMiss;
  logic              rsFault;
  logic [PPN_W-1:0]  rsPpn;
  logic              rsStrongOrd;
  logic              rsWriteBack;
  logic              rfValid = 1'b0;
  logic [VPN_W-1:0]  rfVpn = '0;
  logic [ASID_W-1:0] rfAsid = '0;
  logic [PPN_W-1:0]  rfPpn = '0;
  logic              rfExecNever = 1'b0;
  logic              rfStrongOrd = 1'b0;
  logic              rfWriteBack = 1'b0;
  logic              ivValid = 1'b0;
  logic [1:0]        ivMode = '0;
  logic [VPN_W-1:0]  ivVpn = '0;
  logic [ASID_W-1:0] ivAsid = '0;

  int nChecks = 0;
  int nBad = 0;

  always #5 clk = ~clk;

  asid_tlb #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .PPN_W   (PPN_W),
    .ASID_W  (ASID_W)
  ) i_asid_tlb (.*);

  task automatic checkOut(string tag, logic [1:0] res, logic [7:0] ePpn, logic [1:0] eAttr);
    logic [2:0] expFlags;
    logic [2:0] actFlags;
    expFlags = (res == 2'd1) ? 3'b100 : (res == 2'd2) ? 3'b010 :
               (res == 2'd3) ? 3'b001 : 3'b000;
    actFlags = {rsHit, rsMiss, rsFault};
    nChecks++;
    if (actFlags !== expFlags || rsPpn !== ePpn || {rsStrongOrd, rsWriteBack} !== eAttr) begin
      nBad++;
      $display("FAIL %s: hit/miss/fault=%b ppn=%h attr=%b, expected %b ppn=%h attr=%b",
               tag, actFlags, rsPpn, {rsStrongOrd, rsWriteBack}, expFlags, ePpn, eAttr);
    end
  endtask

  task automatic clearReq();
    lkValid = 1'b0;
    rfValid = 1'b0;
    ivValid = 1'b0;
    lkIsFetch = 1'b0;
  endtask

  task automatic setLook(logic [7:0] vpn, logic [3:0] asid, logic fetch);
    lkValid = 1'b1; lkVpn = vpn; lkAsid = asid; lkIsFetch = fetch;
  endtask

  task automatic setRefill(logic [7:0] vpn, logic [3:0] asid, logic [7:0] ppn, logic [2:0] flg);
    rfValid = 1'b1; rfVpn = vpn; rfAsid = asid; rfPpn = ppn;
    {rfExecNever, rfStrongOrd, rfWriteBack} = flg;
  endtask

  task automatic setInv(logic [7:0] vpn, logic [3:0] asid, logic [1:0] mode);
    ivValid = 1'b1; ivVpn = vpn; ivAsid = asid; ivMode = mode;
  endtask

  // one request cycle, then check the registered result
  task automatic stepCheck(string tag, logic [1:0] res, logic [7:0] ePpn, logic [1:0] eAttr);
    @(negedge clk);
    clearReq();
    checkOut(tag, res, ePpn, eAttr);
  endtask

  task automatic look(string tag, logic [7:0] vpn, logic [3:0] asid, logic fetch,
                      logic [1:0] res, logic [7:0] ePpn, logic [1:0] eAttr);
    setLook(vpn, asid, fetch);
    stepCheck(tag, res, ePpn, eAttr);
  endtask

  task automatic refill(logic [7:0] vpn, logic [3:0] asid, logic [7:0] ppn, logic [2:0] flg);
    setRefill(vpn, asid, ppn, flg);
    @(negedge clk);
    clearReq();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL R2: watchdog expired, cycles=200000 expected completion earlier");
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkOut("R1 outputs in reset", 2'd0, 8'h00, 2'b00);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1 outputs after reset", 2'd0, 8'h00, 2'b00);

    // table walk; non-lookup rows also confirm quiet outputs (R2)
    for (int k = 0; k < NVEC; k++) begin
      vecT v;
      string tag;
      v = VEC[k];
      tag = $sformatf("R%0d row %0d", v.req, k);
      case (v.kind)
        2'd0:    setRefill(v.vpn, v.asid, v.ppn, v.flg);
        2'd1:    setLook(v.vpn, v.asid, v.flg[0]);
        default: setInv(v.vpn, v.asid, v.flg[1:0]);
      endcase
      stepCheck(tag, v.res, v.ePpn, v.eAttr);
    end

    // R8 wrap: store empty, pointer now at entry 3
    refill(8'h80, 4'd5, 8'h80, 3'b000);
    refill(8'h81, 4'd5, 8'h81, 3'b000);
    refill(8'h82, 4'd5, 8'h82, 3'b000);
    refill(8'h83, 4'd5, 8'h83, 3'b000);
    refill(8'h84, 4'd5, 8'h84, 3'b000);  // replaces entry 3
    refill(8'h85, 4'd5, 8'h85, 3'b001);  // pointer wrapped, replaces entry 0
    look("R8 wrap last evicted", 8'h83, 4'd5, 1'b0, 2'd2, 8'h00, 2'b00);
    look("R8 wrap first evicted", 8'h80, 4'd5, 1'b0, 2'd2, 8'h00, 2'b00);
    look("R8 wrap kept", 8'h81, 4'd5, 1'b0, 2'd1, 8'h81, 2'b00);
    look("R8 wrap kept", 8'h82, 4'd5, 1'b0, 2'd1, 8'h82, 2'b00);
    look("R8 wrap new", 8'h85, 4'd5, 1'b0, 2'd1, 8'h85, 2'b01);

    // R12 alternate encoding
    setInv(8'h00, 4'd0, 2'b11);
    stepCheck("R12 mode 11 quiet", 2'd0, 8'h00, 2'b00);
    look("R12 mode 11 cleared", 8'h84, 4'd5, 1'b0, 2'd2, 8'h00, 2'b00);

    // R13 lookup and refill in one cycle
    setRefill(8'h90, 4'd6, 8'h90, 3'b000);
    setLook(8'h90, 4'd6, 1'b0);
    stepCheck("R13 lookup sees old contents", 2'd2, 8'h00, 2'b00);
    look("R13 refill visible next", 8'h90, 4'd6, 1'b0, 2'd1, 8'h90, 2'b00);

    // R13 refill and flush in one cycle
    setRefill(8'h91, 4'd6, 8'h91, 3'b010);
    setInv(8'h00, 4'd0, 2'b10);
    @(negedge clk);
    clearReq();
    look("R13 flush removed older", 8'h90, 4'd6, 1'b0, 2'd2, 8'h00, 2'b00);
    look("R13 refill survives flush", 8'h91, 4'd6, 1'b0, 2'd1, 8'h91, 2'b10);

    // R13 lookup alongside single invalidation
    setInv(8'h91, 4'd6, 2'b00);
    setLook(8'h91, 4'd6, 1'b0);
    stepCheck("R13 lookup before invalidate", 2'd1, 8'h91, 2'b10);
    look("R13 invalidate applied", 8'h91, 4'd6, 1'b0, 2'd2, 8'h00, 2'b00);

    // R1 reset in mid-run empties the store
    refill(8'hA0, 4'd7, 8'hA0, 3'b001);
    look("R1 before reset", 8'hA0, 4'd7, 1'b0, 2'd1, 8'hA0, 2'b01);
    setLook(8'hA0, 4'd7, 1'b0);
    @(negedge clk);
    rstN = 1'b0;
    clearReq();
    @(negedge clk);
    checkOut("R1 reset clears result", 2'd0, 8'h00, 2'b00);
    rstN = 1'b1;
    @(negedge clk);
    look("R1 entries gone", 8'hA0, 4'd7, 1'b0, 2'd2, 8'h00, 2'b00);

    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule